// File: doc/BRIEF.md
# Carry-Save Fused Add-Multiply-Add Unit

This block chains three arithmetic steps in one pass: an addition or subtraction of two operands, a multiplication of a selected value by a binary factor, and a further addition or subtraction of a selected addend. Every operand except the factor travels in carry-save form, as a pair of two's-complement words whose sum is the value. The result leaves in the same pair form, so the unit has no carry-propagate adder. Converting the pair to plain binary is the job of a downstream stage.

Each cycle the unit takes a 4-bit template word together with the operands. The template word and the operands are registered on the same edge, and the result is registered on the next edge. Both pre-multiply and post-multiply steps are 4:2 compressors. The multiplier is an array of partial products that a tree of 4:2 compressors reduces to two words. Subtraction inverts both words of an operand and injects two carry-in ones into the compressor that consumes them.

Top module: `csfma_unit`

## Requirements
- R1: `rst` is synchronous and active high. On the edge where it is sampled high, the template register clears to the all-zero template and both result words clear to zero. They read zero after that edge, whatever the inputs are.
- R2: Template and operands present at clock edge t set the result visible after edge t+1. The template may change on every cycle, and consecutive cycles carry independent operations.
- R3: Template bit 0 selects the first step: N = X + Y when it is 0, N = X − Y when it is 1.
- R4: Template bit 1 selects the multiplicand: N when it is 0, K when it is 1.
- R5: Template bit 2 selects the post-multiply operand: K when it is 0, N when it is 1.
- R6: Template bit 3 selects the sign of the post-multiply step: the operand is added when it is 0 and subtracted when it is 1.
- R7: z_c + z_s, taken modulo 2^16, equals the selected template value (A × multiplicand ± operand) taken modulo 2^16, including results that wrap past −32768 or 32767.
- R8: Any split of a value into two words gives the same result sum, including plain binary operands whose second word is zero.
- R9: A is a signed two's-complement binary word. Negative factors, including −32768 and −1, give the signed product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tmpl | input | 4 | Template word: bit0 pre-subtract, bit1 multiply K, bit2 add N, bit3 post-subtract |
| x_c | input | 16 | Operand X, first word |
| x_s | input | 16 | Operand X, second word |
| y_c | input | 16 | Operand Y, first word |
| y_s | input | 16 | Operand Y, second word |
| k_c | input | 16 | Operand K, first word |
| k_s | input | 16 | Operand K, second word |
| a | input | 16 | Binary two's-complement factor |
| z_c | output | 16 | Result, first word |
| z_s | output | 16 | Result, second word |

## Verification
The bench builds the unit only with the default width of 16 bits. At that width all sixteen template words fit in one table, and the 32-row partial-product array passes through the full four-level compressor tree. At that width, operands of −32768 and 32767 and factors of −1 and −32768 force every wrap in the compressors and the product. The bench also supplies one value under several word splits, issues templates back to back to expose pipeline cross-talk, and asserts reset partway through an operation.

// File: rtl/csfma_unit.sv
module csfma_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   tmpl,
  input  logic [W-1:0] x_c,
  input  logic [W-1:0] x_s,
  input  logic [W-1:0] y_c,
  input  logic [W-1:0] y_s,
  input  logic [W-1:0] k_c,
  input  logic [W-1:0] k_s,
  input  logic [W-1:0] a,
  output logic [W-1:0] z_c,
  output logic [W-1:0] z_s
);
  localparam int PP = 2 * W;
  localparam int LV = $clog2(PP) - 1;

  // two rows of full adders; ci is injected into both freed carry LSBs
  function automatic logic [2*W-1:0] cmp42(input logic [W-1:0] p, q, r, t,
                                           input logic ci);
    logic [W-1:0] s1, c1, s2, c2;
    s1 = p ^ q ^ r;
    c1 = (((p & q) | (p & r) | (q & r)) << 1) | W'(ci);
    s2 = s1 ^ c1 ^ t;
    c2 = (((s1 & c1) | (s1 & t) | (c1 & t)) << 1) | W'(ci);
    return {c2, s2};
  endfunction

  logic [3:0]   tm_q;
  logic [W-1:0] xc_q, xs_q, yc_q, ys_q, kc_q, ks_q, a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_q <= '0;
      xc_q <= '0; xs_q <= '0; yc_q <= '0; ys_q <= '0;
      kc_q <= '0; ks_q <= '0; a_q <= '0;
    end else begin
      tm_q <= tmpl;
      xc_q <= x_c; xs_q <= x_s; yc_q <= y_c; ys_q <= y_s;
      kc_q <= k_c; ks_q <= k_s; a_q <= a;
    end
  end

  wire pre_sub  = tm_q[0];
  wire mul_k    = tm_q[1];
  wire add_n    = tm_q[2];
  wire post_sub = tm_q[3];

  logic [W-1:0] ycm, ysm, n_c, n_s, m_c, m_s, d_c, d_s, dc_x, ds_x;

  assign ycm = pre_sub ? ~yc_q : yc_q;
  assign ysm = pre_sub ? ~ys_q : ys_q;
  assign {n_c, n_s} = cmp42(xc_q, xs_q, ycm, ysm, pre_sub);

  assign m_c = mul_k ? kc_q : n_c;
  assign m_s = mul_k ? ks_q : n_s;
  assign d_c = add_n ? n_c : kc_q;
  assign d_s = add_n ? n_s : ks_q;
  assign dc_x = post_sub ? ~d_c : d_c;
  assign ds_x = post_sub ? ~d_s : d_s;

  // partial-product array and 4:2 reduction tree
  logic [W-1:0] tr [LV+1][PP];

  for (genvar j = 0; j < W; j++) begin : g_pp
    assign tr[0][j]     = m_c[j] ? (a_q << j) : '0;
    assign tr[0][W + j] = m_s[j] ? (a_q << j) : '0;
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar g = 0; g < (PP >> (l + 2)); g++) begin : g_grp
      assign {tr[l+1][2*g+1], tr[l+1][2*g]} =
        cmp42(tr[l][4*g], tr[l][4*g+1], tr[l][4*g+2], tr[l][4*g+3], 1'b0);
    end
    for (genvar r = (PP >> (l + 1)); r < PP; r++) begin : g_pad
      assign tr[l+1][r] = '0;
    end
  end

  logic [W-1:0] f_c, f_s;
  assign {f_c, f_s} = cmp42(tr[LV][0], tr[LV][1], dc_x, ds_x, post_sub);

  always_ff @(posedge clk) begin
    if (rst) begin
      z_c <= '0;
      z_s <= '0;
    end else begin
      z_c <= f_c;
      z_s <= f_s;
    end
  end

  // behavioural reference used only by the checks below
  function automatic logic [W-1:0] ref_val(input logic [3:0] t,
      input logic [W-1:0] xc, xs, yc, ys, kc, ks, fa);
    logic [W-1:0] nv, kv, mv, dv;
    nv = t[0] ? (xc + xs - yc - ys) : (xc + xs + yc + ys);
    kv = kc + ks;
    mv = t[1] ? kv : nv;
    dv = t[2] ? nv : kv;
    return t[3] ? (fa * mv - dv) : (fa * mv + dv);
  endfunction

  wire [4+7*W-1:0] in_bus = {tmpl, x_c, x_s, y_c, y_s, k_c, k_s, a};

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (z_c == '0 && z_s == '0));

  a_r1_template_clear: assert property (@(posedge clk)
    rst |=> (tm_q == 4'b0000));

  // covers R3, R4, R5, R6, R7
  a_r7_template_value: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |->
      (W'(z_c + z_s) == ref_val($past(tmpl, 2), $past(x_c, 2), $past(x_s, 2),
                                $past(y_c, 2), $past(y_s, 2), $past(k_c, 2),
                                $past(k_s, 2), $past(a, 2))));

  a_r2_repeatable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && $past($stable(in_bus), 2))
      |-> $stable({z_c, z_s}));

endmodule

// File: tb/csfma_unit_tb.sv
`timescale 1ns/1ps
module csfma_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  tmpl = '0;
  logic [15:0] x_c = '0, x_s = '0, y_c = '0, y_s = '0, k_c = '0, k_s = '0, a = '0;
  logic [15:0] z_c, z_s;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  csfma_unit u_dut (.clk(clk), .rst(rst), .tmpl(tmpl), .x_c(x_c), .x_s(x_s),
                    .y_c(y_c), .y_s(y_s), .k_c(k_c), .k_s(k_s), .a(a),
                    .z_c(z_c), .z_s(z_s));

  typedef struct packed {
    logic [3:0]  t;
    logic [15:0] xc, xs, yc, ys, kc, ks, fa;
  } vec_t;

  localparam vec_t VT [16] = '{
    '{4'h0, 16'h0003, 16'h0004, 16'h0001, 16'h0001, 16'h0005, 16'h0000, 16'h0003},
    '{4'h1, 16'h7FFF, 16'h0001, 16'h0002, 16'hFFFF, 16'h0010, 16'h0020, 16'h0005},
    '{4'h2, 16'h1234, 16'h0000, 16'h0000, 16'h4321, 16'h8000, 16'h0000, 16'hFFFF},
    '{4'h3, 16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h7FFF, 16'h7FFF, 16'h7FFF},
    '{4'h4, 16'h8000, 16'h8000, 16'h1111, 16'h2222, 16'h0003, 16'h0003, 16'h8000},
    '{4'h5, 16'h00FF, 16'hFF00, 16'h0F0F, 16'hF0F0, 16'hABCD, 16'h1234, 16'h0101},
    '{4'h6, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    '{4'h7, 16'h0064, 16'h0000, 16'h0000, 16'h0032, 16'h0007, 16'h0000, 16'hFFF9},
    '{4'h8, 16'h0005, 16'h0000, 16'h0000, 16'h0000, 16'h0007, 16'h0000, 16'h0002},
    '{4'h9, 16'h8000, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0001},
    '{4'hA, 16'h7FFF, 16'h0000, 16'h7FFF, 16'h0000, 16'h0002, 16'h0003, 16'h8001},
    '{4'hB, 16'h1357, 16'h2468, 16'h9ABC, 16'hDEF0, 16'h0F1E, 16'h2D3C, 16'h00C3},
    '{4'hC, 16'h4000, 16'h4000, 16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h0002},
    '{4'hD, 16'h0000, 16'h8000, 16'h8000, 16'h0000, 16'h0000, 16'h0001, 16'h7FFF},
    '{4'hE, 16'h5555, 16'hAAAA, 16'h3333, 16'hCCCC, 16'h0000, 16'hFFFF, 16'h1234},
    '{4'hF, 16'hFFFE, 16'h0001, 16'h0003, 16'h0004, 16'h0100, 16'h0200, 16'hFFFF}
  };

  // signed integer model of the requirements, wrapped to 16 bits at the end
  function automatic logic [15:0] model(vec_t v);
    int nv, kv, mv, dv, r;
    nv = int'($signed(v.xc)) + int'($signed(v.xs));
    if (v.t[0]) nv = nv - int'($signed(v.yc)) - int'($signed(v.ys));
    else        nv = nv + int'($signed(v.yc)) + int'($signed(v.ys));
    kv = int'($signed(v.kc)) + int'($signed(v.ks));
    mv = v.t[1] ? kv : nv;
    dv = v.t[2] ? nv : kv;
    r  = int'($signed(v.fa)) * mv;
    r  = v.t[3] ? r - dv : r + dv;
    return r[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    tmpl = v.t; x_c = v.xc; x_s = v.xs; y_c = v.yc; y_s = v.ys;
    k_c = v.kc; k_s = v.ks; a = v.fa;
  endtask

  task automatic run1(input vec_t v, output logic [15:0] s);
    @(negedge clk); drive(v);
    @(posedge clk); @(posedge clk); #1;
    s = z_c + z_s;
  endtask

  function automatic vec_t mk(input logic [3:0] t, input logic [15:0] xc, xs, yc, ys, kc, ks, fa);
    vec_t v;
    v.t = t; v.xc = xc; v.xs = xs; v.yc = yc; v.ys = ys; v.kc = kc; v.ks = ks; v.fa = fa;
    return v;
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] s, s2;
    // R1: reset held with busy inputs keeps results at zero
    drive(VT[5]);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset z_c", z_c, 16'h0000);
    check("R1 reset z_s", z_s, 16'h0000);
    rst = 1'b0;

    // R7 with R3..R6 via bits of the template: table of all templates
    for (int i = 0; i < 16; i++) begin
      run1(VT[i], s);
      check($sformatf("R7 table template %0d", i), s, model(VT[i]));
    end

    // R3: plain add and pre-subtract, hand values
    run1(mk(4'h0, 16'd3, 16'd4, 16'd1, 16'd1, 16'd5, 16'd0, 16'd3), s);
    check("R3 add 3*(7+2)+5", s, 16'd32);
    run1(mk(4'h1, 16'd10, 16'd0, 16'd2, 16'd1, 16'd0, 16'd0, 16'd2), s);
    check("R3 sub 2*(10-3)", s, 16'd14);
    // R4 and R5: K multiplied, N added
    run1(mk(4'h6, 16'd1, 16'd1, 16'd1, 16'd0, 16'd4, 16'd1, 16'd6), s);
    check("R4 R5 6*5+3", s, 16'd33);
    run1(mk(4'h2, 16'd1, 16'd1, 16'd1, 16'd0, 16'd4, 16'd1, 16'd6), s);
    check("R4 6*5+5", s, 16'd35);
    // R6: post-subtract
    run1(mk(4'h8, 16'd5, 16'd0, 16'd0, 16'd0, 16'd7, 16'd0, 16'd2), s);
    check("R6 2*5-7", s, 16'd3);
    run1(mk(4'h8, 16'd2, 16'd0, 16'd0, 16'd0, 16'd7, 16'd0, 16'd1), s);
    check("R6 2-7", s, 16'hFFFB);
    // R7: wrap at extremes
    run1(mk(4'h0, 16'h7FFF, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0001), s);
    check("R7 32767+1 wraps", s, 16'h8000);
    run1(mk(4'h9, 16'h8000, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0001), s);
    check("R7 -32768-1 wraps", s, 16'h7FFF);
    // R9: negative factors
    run1(mk(4'h0, 16'h8000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF), s);
    check("R9 -1*-32768", s, 16'h8000);
    run1(mk(4'h0, 16'd5, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'hFFFE), s);
    check("R9 -2*5", s, 16'hFFF6);

    // R8: one value in different word splits, binary form included
    run1(mk(4'h0, 16'd100, 16'd0, 16'd0, 16'd0, 16'd9, 16'd0, 16'd3), s);
    check("R8 binary form", s, 16'd309);
    run1(mk(4'h0, 16'd60, 16'd40, 16'd0, 16'd0, 16'd4, 16'd5, 16'd3), s2);
    check("R8 split 60+40", s2, s);
    run1(mk(4'h0, 16'hFFFF, 16'd101, 16'd0, 16'd0, 16'hFFF7, 16'd18, 16'd3), s2);
    check("R8 split with wrap", s2, s);

    // R2: back-to-back templates, one result per cycle
    @(negedge clk); drive(VT[1]);
    @(negedge clk); drive(VT[6]);
    @(negedge clk); check("R2 stream 0", z_c + z_s, model(VT[1])); drive(VT[11]);
    @(negedge clk); check("R2 stream 1", z_c + z_s, model(VT[6])); drive(VT[14]);
    @(negedge clk); check("R2 stream 2", z_c + z_s, model(VT[11]));
    @(negedge clk); check("R2 stream 3", z_c + z_s, model(VT[14]));

    // R1: reset in the middle of an operation
    @(negedge clk); drive(VT[10]); rst = 1'b1;
    @(negedge clk); check("R1 mid reset z_c", z_c, 16'h0000);
    check("R1 mid reset z_s", z_s, 16'h0000);
    @(negedge clk); check("R1 mid reset held", z_c | z_s, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk); check("R1 recovery", z_c + z_s, model(VT[10]));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule